// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This unit decides, at each instruction boundary of an 8-bit CPU, whether the core must leave its normal flow to service an event. It watches an active-low non-maskable request line, an active-low maskable request line, the interrupt-disable bit of the current status byte, and a flag that says the opcode just fetched is the software-break opcode. When an event is taken, the unit saves the return state itself. It writes the program counter high byte, the program counter low byte and a status byte to the stack page through a simple write port. It then reports the handler vector, the new stack pointer and the updated status byte.

The non-maskable line acts on its falling edge. The edge is held in a pending latch until it is serviced, and a line kept low yields one request only. The maskable line acts on its level and is gated by the interrupt-disable bit. The non-maskable request wins over the other two sources. A hardware request taken at a boundary where a break opcode was fetched replaces the break, and the break is dropped. The break marker has no storage of its own: it appears only in the pushed status byte. The decimal-mode bit passes through entry unchanged.

Top module: `irq_entry_seq`

## Requirements
- R1: A falling edge on `nmi_n` sets a pending request that is serviced at the first accepted boundary at least one clock later; holding `nmi_n` low yields no second service, and a release followed by a new fall yields a new one.
- R2: With no non-maskable request pending, a boundary with `irq_n` low and status bit 2 (interrupt-disable) clear is serviced as a maskable event; with status bit 2 set, the maskable line is ignored.
- R3: When a non-maskable request and a maskable request are both present, the non-maskable one is serviced first, and a maskable line still low is serviced at the next accepted boundary.
- R4: A break opcode flagged on `brk_op` is serviced only when no hardware request is taken at that boundary; otherwise it is lost and not serviced later.
- R5: One clock after an accepted boundary, three stack writes follow on consecutive cycles: PC high byte at address {0x01, sp}, PC low byte at {0x01, sp-1}, status at {0x01, sp-2}, with 8-bit wrap of the stack pointer.
- R6: Bit 4 of the pushed status byte is 1 for a break event and 0 for a non-maskable or maskable event; every other bit equals `status_in`.
- R7: On the cycle after the last write, `vec_valid` pulses for one clock with `vec_src` coded 1 for non-maskable, 2 for maskable, 3 for break, and `vec_addr` 0xFFFA for non-maskable and 0xFFFE for the other two; `sp_out` equals sp-3.
- R8: With that pulse, `status_out` equals `status_in` with bit 2 set and bit 4 clear; bit 3 (decimal mode) is left as it was.
- R9: `busy` is high for the four cycles of a sequence, and a boundary during those cycles is not taken; a boundary held high is taken on the first cycle after the sequence.
- R10: After reset, `busy`, `stk_we` and `vec_valid` are low and no non-maskable request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_n | input | 1 | Non-maskable request, active low, edge acting |
| irq_n | input | 1 | Maskable request, active low, level acting |
| boundary | input | 1 | Instruction boundary strobe from the core |
| brk_op | input | 1 | Fetched opcode is the software break |
| pc_in | input | 16 | Return address to save |
| sp_in | input | 8 | Current stack pointer |
| status_in | input | 8 | Current status byte |
| busy | output | 1 | Entry sequence in progress |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 16 | Stack write address |
| stk_wdata | output | 8 | Stack write data |
| vec_valid | output | 1 | One-cycle pulse: vector and new state valid |
| vec_addr | output | 16 | Address of the handler vector |
| vec_src | output | 2 | Serviced source: 1 non-maskable, 2 maskable, 3 break |
| sp_out | output | 8 | Stack pointer after the three pushes |
| status_out | output | 8 | Status byte after entry |

## Verification
A falling `nmi_n` must precede the boundary strobe by at least one clock edge to be seen there. The write of the PC high byte is visible one clock after the boundary edge, the low byte and status on the next two clocks, and the vector pulse on the fourth. The bench drives every input on the falling clock edge, counts these edges after the accepting edge, and samples each result on the falling edge of the cycle where it is due. A quiet cycle between sequences is checked where the boundary is held high. A reference model in the bench carries its own pending flag for the non-maskable edge and picks the expected source from the same inputs the bench applied.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_IRQ  = 2'd2,
    SRC_BRK  = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PH   = 3'd1,
    ST_PL   = 3'd2,
    ST_PS   = 3'd3,
    ST_VEC  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic take,
  output logic pend
);
  logic prev;
  logic fall;

  assign fall = prev & ~nmi_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b1;
      pend <= 1'b0;
    end else begin
      prev <= nmi_n;
      pend <= fall | (pend & ~take);
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_seq_pkg::*;
(
  input  logic pend_nmi,
  input  logic irq_n,
  input  logic i_mask,
  input  logic brk_op,
  output src_e src
);
  always_comb begin
    if (pend_nmi)                src = SRC_NMI;
    else if (!irq_n && !i_mask)  src = SRC_IRQ;
    else if (brk_op)             src = SRC_BRK;
    else                         src = SRC_NONE;
  end
endmodule

// File: rtl/irq_push_seq.sv
module irq_push_seq
  import irq_seq_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DW         = 8,
  parameter int          SPW        = 8,
  parameter logic [AW-SPW-1:0] STACK_PAGE = 'h01,
  parameter logic [AW-1:0] NMI_VEC  = 16'hFFFA,
  parameter logic [AW-1:0] IRQ_VEC  = 16'hFFFE,
  parameter logic [AW-1:0] BRK_VEC  = 16'hFFFE,
  parameter int          I_BIT      = 2,
  parameter int          B_BIT      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  src_e          src,
  input  logic [AW-1:0] pc_in,
  input  logic [SPW-1:0] sp_in,
  input  logic [DW-1:0] status_in,
  output logic          busy,
  output logic          stk_we,
  output logic [AW-1:0] stk_addr,
  output logic [DW-1:0] stk_wdata,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr,
  output logic [1:0]    vec_src,
  output logic [SPW-1:0] sp_out,
  output logic [DW-1:0] status_out
);
  localparam logic [SPW-1:0] ONE = SPW'(1);

  seq_st_e        st;
  src_e           src_q;
  logic [DW-1:0]  pcl_q;
  logic [SPW-1:0] sp_q;
  logic [DW-1:0]  stat_q;
  logic [DW-1:0]  push_stat;
  logic [AW-1:0]  vec_sel;

  assign busy = (st != ST_IDLE);

  always_comb begin
    push_stat        = stat_q;
    push_stat[B_BIT] = (src_q == SRC_BRK);
  end

  always_comb begin
    case (src_q)
      SRC_NMI: vec_sel = NMI_VEC;
      SRC_IRQ: vec_sel = IRQ_VEC;
      default: vec_sel = BRK_VEC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      src_q      <= SRC_NONE;
      pcl_q      <= '0;
      sp_q       <= '0;
      stat_q     <= '0;
      stk_we     <= 1'b0;
      stk_addr   <= '0;
      stk_wdata  <= '0;
      vec_valid  <= 1'b0;
      vec_addr   <= '0;
      vec_src    <= 2'd0;
      sp_out     <= '0;
      status_out <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          vec_valid  <= 1'b0;
          if (start) begin
            st        <= ST_PH;
            src_q     <= src;
            pcl_q     <= pc_in[DW-1:0];
            sp_q      <= sp_in;
            stat_q    <= status_in;
            stk_we    <= 1'b1;
            stk_addr  <= {STACK_PAGE, sp_in};
            stk_wdata <= pc_in[AW-1 -: DW];
          end
        end
        ST_PH: begin
          st        <= ST_PL;
          stk_addr  <= {STACK_PAGE, sp_q - ONE};
          stk_wdata <= pcl_q;
        end
        ST_PL: begin
          st        <= ST_PS;
          stk_addr  <= {STACK_PAGE, sp_q - SPW'(2)};
          stk_wdata <= push_stat;
        end
        ST_PS: begin
          st         <= ST_VEC;
          stk_we     <= 1'b0;
          stk_addr   <= '0;
          stk_wdata  <= '0;
          vec_valid  <= 1'b1;
          vec_addr   <= vec_sel;
          vec_src    <= src_q;
          sp_out     <= sp_q - SPW'(3);
          status_out <= stat_q | (DW'(1) << I_BIT);
          status_out[B_BIT] <= 1'b0;
        end
        default: begin
          st         <= ST_IDLE;
          vec_valid  <= 1'b0;
          vec_addr   <= '0;
          vec_src    <= 2'd0;
          sp_out     <= '0;
          status_out <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int SPW = 8,
  parameter logic [AW-SPW-1:0] STACK_PAGE = 'h01,
  parameter logic [AW-1:0] NMI_VEC = 16'hFFFA,
  parameter logic [AW-1:0] IRQ_VEC = 16'hFFFE,
  parameter logic [AW-1:0] BRK_VEC = 16'hFFFE,
  parameter int I_BIT = 2,
  parameter int B_BIT = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           nmi_n,
  input  logic           irq_n,
  input  logic           boundary,
  input  logic           brk_op,
  input  logic [AW-1:0]  pc_in,
  input  logic [SPW-1:0] sp_in,
  input  logic [DW-1:0]  status_in,
  output logic           busy,
  output logic           stk_we,
  output logic [AW-1:0]  stk_addr,
  output logic [DW-1:0]  stk_wdata,
  output logic           vec_valid,
  output logic [AW-1:0]  vec_addr,
  output logic [1:0]     vec_src,
  output logic [SPW-1:0] sp_out,
  output logic [DW-1:0]  status_out
);
  logic pend_nmi;
  logic accept;
  logic take_nmi;
  src_e src;

  assign accept   = boundary & ~busy & (src != SRC_NONE);
  assign take_nmi = accept & (src == SRC_NMI);

  irq_nmi_latch u_nmi (
    .clk   (clk),
    .rst   (rst),
    .nmi_n (nmi_n),
    .take  (take_nmi),
    .pend  (pend_nmi)
  );

  irq_pick u_pick (
    .pend_nmi (pend_nmi),
    .irq_n    (irq_n),
    .i_mask   (status_in[I_BIT]),
    .brk_op   (brk_op),
    .src      (src)
  );

  irq_push_seq #(
    .AW(AW), .DW(DW), .SPW(SPW), .STACK_PAGE(STACK_PAGE),
    .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC), .BRK_VEC(BRK_VEC),
    .I_BIT(I_BIT), .B_BIT(B_BIT)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .src        (src),
    .pc_in      (pc_in),
    .sp_in      (sp_in),
    .status_in  (status_in),
    .busy       (busy),
    .stk_we     (stk_we),
    .stk_addr   (stk_addr),
    .stk_wdata  (stk_wdata),
    .vec_valid  (vec_valid),
    .vec_addr   (vec_addr),
    .vec_src    (vec_src),
    .sp_out     (sp_out),
    .status_out (status_out)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SPW = 8,
  parameter logic [AW-1:0] NMI_VEC = 16'hFFFA,
  parameter int I_BIT = 2,
  parameter int B_BIT = 4,
  parameter int D_BIT = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           stk_we,
  input logic [AW-1:0]  stk_addr,
  input logic [DW-1:0]  stk_wdata,
  input logic           vec_valid,
  input logic [AW-1:0]  vec_addr,
  input logic [1:0]     vec_src,
  input logic [DW-1:0]  status_out
);
  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (stk_we && $past(stk_we)) |-> (stk_addr[SPW-1:0] == $past(stk_addr[SPW-1:0]) - SPW'(1)));

  p_vec_after_push_r7: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ($past(stk_we) && !stk_we));

  p_nmi_vec_r7: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && vec_src == 2'd1) |-> (vec_addr == NMI_VEC));

  p_brk_bit_r6: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ($past(stk_wdata[B_BIT]) == (vec_src == 2'd3)));

  p_dec_kept_r8: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (status_out[D_BIT] == $past(stk_wdata[D_BIT]) && status_out[I_BIT]));

  p_end_idle_r9: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> (!busy && !vec_valid));

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stk_we, vec_valid}));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .AW(AW), .DW(DW), .SPW(SPW), .NMI_VEC(NMI_VEC), .I_BIT(I_BIT), .B_BIT(B_BIT)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .stk_we(stk_we), .stk_addr(stk_addr),
  .stk_wdata(stk_wdata), .vec_valid(vec_valid), .vec_addr(vec_addr),
  .vec_src(vec_src), .status_out(status_out)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_n = 1'b1;
  logic        irq_n = 1'b1;
  logic        boundary = 1'b0;
  logic        brk_op = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  sp_in = '0;
  logic [7:0]  status_in = '0;
  logic        busy, stk_we, vec_valid;
  logic [15:0] stk_addr, vec_addr;
  logic [7:0]  stk_wdata, sp_out, status_out;
  logic [1:0]  vec_src;

  int n_vec = 0;
  int n_bad = 0;
  bit pend_m = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_entry_seq u_dut (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .irq_n(irq_n), .boundary(boundary),
    .brk_op(brk_op), .pc_in(pc_in), .sp_in(sp_in), .status_in(status_in),
    .busy(busy), .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_src(vec_src),
    .sp_out(sp_out), .status_out(status_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] pick_exp();
    if (pend_m)                        return 2'd1;
    if (!irq_n && !status_in[2])       return 2'd2;
    if (brk_op)                        return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [7:0] push_byte(input logic [1:0] s);
    logic [7:0] b;
    b = status_in;
    b[4] = (s == 2'd3);
    return b;
  endfunction

  function automatic logic [15:0] vec_of(input logic [1:0] s);
    return (s == 2'd1) ? 16'hFFFA : 16'hFFFE;
  endfunction

  task automatic set_nmi(input logic v);
    @(negedge clk);
    if (nmi_n && !v) pend_m = 1'b1;
    nmi_n = v;
  endtask

  // Called at the falling edge right after the accepting rising edge.
  task automatic check_seq(input logic [1:0] s, input string tag);
    logic [7:0] sp;
    sp = sp_in;
    if (s == 2'd0) begin
      chk({tag, " no service busy"}, busy, 0);
      chk({tag, " no service write"}, stk_we, 0);
      return;
    end
    if (s == 2'd1) pend_m = 1'b0;
    chk({tag, " R5 pch we"}, stk_we, 1);
    chk({tag, " R5 pch addr"}, stk_addr, {8'h01, sp});
    chk({tag, " R5 pch data"}, stk_wdata, pc_in[15:8]);
    chk({tag, " R9 busy"}, busy, 1);
    @(negedge clk);
    chk({tag, " R5 pcl addr"}, stk_addr, {8'h01, 8'(sp - 8'd1)});
    chk({tag, " R5 pcl data"}, stk_wdata, pc_in[7:0]);
    @(negedge clk);
    chk({tag, " R5 stat addr"}, stk_addr, {8'h01, 8'(sp - 8'd2)});
    chk({tag, " R6 stat data"}, stk_wdata, push_byte(s));
    @(negedge clk);
    chk({tag, " R7 vec valid"}, {vec_valid, stk_we}, 2'b10);
    chk({tag, " R7 vec src"}, vec_src, s);
    chk({tag, " R7 vec addr"}, vec_addr, vec_of(s));
    chk({tag, " R7 sp out"}, sp_out, 8'(sp - 8'd3));
    chk({tag, " R8 status out"}, status_out, (status_in | 8'h04) & 8'hEF);
  endtask

  task automatic run_bd(input logic [1:0] s_force, input bit use_force, input string tag);
    logic [1:0] s;
    @(negedge clk);
    boundary = 1'b1;
    s = use_force ? s_force : pick_exp();
    @(negedge clk);
    boundary = 1'b0;
    check_seq(s, tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset we", stk_we, 0);
    chk("R10 reset vec", vec_valid, 0);
    rst = 1'b0;
    pc_in = 16'h1234; sp_in = 8'hFD; status_in = 8'h20;
    run_bd(2'd0, 1, "R10 no pending after reset");

    // maskable, decimal set, mask clear
    irq_n = 1'b0; status_in = 8'h28; pc_in = 16'hABCD;
    run_bd(2'd2, 1, "R2 irq taken");
    // masked
    status_in = 8'h2C;
    run_bd(2'd0, 1, "R2 irq masked");
    irq_n = 1'b1; status_in = 8'h20;

    // edge behaviour
    set_nmi(1'b0);
    run_bd(2'd1, 1, "R1 nmi edge");
    run_bd(2'd0, 1, "R1 nmi held low");
    set_nmi(1'b1);
    set_nmi(1'b0);
    run_bd(2'd1, 1, "R1 nmi new edge");
    set_nmi(1'b1);

    // both together, then maskable follows
    set_nmi(1'b0);
    irq_n = 1'b0;
    run_bd(2'd1, 1, "R3 nmi first");
    run_bd(2'd2, 1, "R3 irq after");
    irq_n = 1'b1;
    set_nmi(1'b1);

    // break lost to hardware, then served alone
    irq_n = 1'b0; brk_op = 1'b1; pc_in = 16'h4000;
    run_bd(2'd2, 1, "R4 brk lost");
    irq_n = 1'b1; brk_op = 1'b0;
    run_bd(2'd0, 1, "R4 brk not replayed");
    brk_op = 1'b1; status_in = 8'h39;
    run_bd(2'd3, 1, "R4 brk served");
    brk_op = 1'b0;

    // boundary held through a sequence; stack pointer wrap
    irq_n = 1'b0; status_in = 8'h20; sp_in = 8'h01;
    @(negedge clk);
    boundary = 1'b1;
    @(negedge clk);
    check_seq(2'd2, "R9 held first");
    @(negedge clk);
    chk("R9 gap busy", busy, 0);
    chk("R9 gap write", stk_we, 0);
    @(negedge clk);
    boundary = 1'b0;
    check_seq(2'd2, "R9 held second");
    irq_n = 1'b1;

    // constrained random
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 3);
      if (r == 0) set_nmi(~nmi_n);
      irq_n     = ($urandom_range(0, 2) != 0);
      brk_op    = ($urandom_range(0, 2) == 0);
      pc_in     = 16'($urandom);
      sp_in     = 8'($urandom);
      status_in = 8'($urandom);
      run_bd(2'd0, 0, "R1 R2 R3 R4 random");
    end
    finish_up();
  end
endmodule